// File: doc/BRIEF.md
# System Control Register File

This block is a memory-mapped bank of 32-bit control and status words that occupies a 4 KB address window. A single-cycle register bus reaches it: the requester raises a select strobe together with a direction bit, a byte address and write data. Writes take effect at the clock edge. Read data is registered and is valid in the cycle after the strobe. The bus never stalls.

Only the lower half of the window is backed by storage. A small set of locations behaves differently from plain storage. Three words read back with two status bits forced high. One command address in the unbacked upper half turns written codes into platform reset or power-off request pulses. Any access to the unbacked half is discarded and raises a one-cycle bad-access flag. Four words come out of reset with fixed identification and configuration values.

Top module: `sysctl_regfile`

## Requirements
- R1: After reset, the word at byte offset 0x100 holds 0x05F20121, 0x104 holds 0x00000002, 0x108 holds 0x05F30121 and 0x10C holds 0x05F40121. All other backed words hold zero.
- R2: A write with the select strobe high stores the full 32-bit data in the word addressed by byte offset divided by 4, for offsets 0x000 to 0x7FC. A read strobe returns that word on the read data output in the next cycle.
- R3: Reads of byte offsets 0x100, 0x108 and 0x10C return the stored word OR 0x30000000 (bits 29 and 28 set). The stored value keeps its own bits 29:28. Every other backed offset reads back unmodified.
- R4: A write at byte offset 0x800 or above changes no stored word. In particular it does not alias onto the word at the offset minus 0x800.
- R5: A read at byte offset 0x800 or above returns zero.
- R6: A write to byte offset 0xF00 with data 1 or 2 drives the reset-request output high for exactly the one cycle after the write.
- R7: A write to byte offset 0xF00 with data 3 drives the shutdown-request output high for exactly the one cycle after the write. Any other data value at 0xF00 raises neither request.
- R8: The bad-access output is high for exactly the one cycle after any read or write at byte offset 0x800 or above, including the command offset 0xF00. It stays low after accesses below 0x800.
- R9: The reset-request and shutdown-request outputs are never high in the same cycle. Shutdown takes priority if both would apply.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_sel | input | 1 | Access strobe, one access per high cycle |
| bus_write | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 12 | Byte offset inside the window, word aligned |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid the cycle after a read strobe |
| bad_access | output | 1 | Pulse, the cycle after an access to the unbacked half |
| reset_req | output | 1 | Pulse requesting a platform reset |
| shutdown_req | output | 1 | Pulse requesting platform power-off |

## Verification
Every result of this block is due exactly one cycle after its strobe. This covers read data, the bad-access flag and both request pulses; stored writes become visible to the next read. Each bench access drives the strobe at a falling edge, lets one rising edge pass, then drops the strobe and samples all four results at the following falling edge. Directed sequences also sample one more falling edge later to confirm that each pulse has cleared. A shadow model updated only by in-range writes supplies every expected read value.

// File: rtl/sysctl_pkg.sv
package sysctl_pkg;

   typedef enum logic [1:0] {
      CMD_NONE  = 2'd0,
      CMD_RESET = 2'd1,
      CMD_OFF   = 2'd2
   } sysctl_cmd_e;

   // bits forced high when certain status words are read
   localparam logic [31:0] STATUS_FORCE = 32'h3000_0000;

   // word indices whose reads carry the forced bits
   localparam int unsigned FORCE_IDX_A = 'h40;
   localparam int unsigned FORCE_IDX_B = 'h42;
   localparam int unsigned FORCE_IDX_C = 'h43;

   // value a backed word takes at reset
   function automatic logic [31:0] boot_value(input int unsigned idx);
      case (idx)
         'h40:    return 32'h05F2_0121;
         'h41:    return 32'h0000_0002;
         'h42:    return 32'h05F3_0121;
         'h43:    return 32'h05F4_0121;
         default: return 32'h0000_0000;
      endcase
   endfunction

endpackage

// File: rtl/sysctl_store.sv
module sysctl_store
   import sysctl_pkg::*;
#(
   parameter int unsigned WORDS  = 512,
   parameter int unsigned DATA_W = 32,
   localparam int unsigned IDX_W = $clog2(WORDS)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en,
   input  logic [IDX_W-1:0]  wr_idx,
   input  logic [DATA_W-1:0] wr_data,
   input  logic [IDX_W-1:0]  rd_idx,
   output logic [DATA_W-1:0] rd_word
);

   logic [DATA_W-1:0] mem [WORDS];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         for (int i = 0; i < WORDS; i++) begin
            mem[i] <= DATA_W'(boot_value(i));
         end
      end else if (wr_en) begin
         mem[wr_idx] <= wr_data;
      end
   end

   assign rd_word = mem[rd_idx];

endmodule

// File: rtl/sysctl_cmd_decode.sv
module sysctl_cmd_decode
   import sysctl_pkg::*;
#(
   parameter int unsigned DATA_W = 32
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cmd_hit,
   input  logic [DATA_W-1:0] cmd_data,
   output logic              reset_req,
   output logic              shutdown_req
);

   sysctl_cmd_e cmd_now;

   // power-off is tested first so it wins over reset
   always_comb begin
      cmd_now = CMD_NONE;
      if (cmd_hit) begin
         if (cmd_data == DATA_W'(3)) begin
            cmd_now = CMD_OFF;
         end else if (cmd_data == DATA_W'(1) || cmd_data == DATA_W'(2)) begin
            cmd_now = CMD_RESET;
         end
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         reset_req    <= 1'b0;
         shutdown_req <= 1'b0;
      end else begin
         reset_req    <= (cmd_now == CMD_RESET);
         shutdown_req <= (cmd_now == CMD_OFF);
      end
   end

   // R9: the two requests are mutually exclusive
   p_req_exclusive_r9: assert property (@(posedge clk) disable iff (!rst_n)
      !(reset_req && shutdown_req));

endmodule

// File: rtl/sysctl_read_path.sv
module sysctl_read_path
   import sysctl_pkg::*;
#(
   parameter int unsigned WORDS    = 512,
   parameter int unsigned DATA_W   = 32,
   parameter bit          FORCE_EN = 1'b1,
   localparam int unsigned IDX_W   = $clog2(WORDS)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              rd_en,
   input  logic              in_range,
   input  logic [IDX_W-1:0]  rd_idx,
   input  logic [DATA_W-1:0] rd_word,
   output logic [DATA_W-1:0] rdata
);

   logic [DATA_W-1:0] shown;

   generate
      if (FORCE_EN) begin : g_force
         logic hit;
         assign hit = (rd_idx == IDX_W'(FORCE_IDX_A)) ||
                      (rd_idx == IDX_W'(FORCE_IDX_B)) ||
                      (rd_idx == IDX_W'(FORCE_IDX_C));
         assign shown = hit ? (rd_word | DATA_W'(STATUS_FORCE)) : rd_word;
      end else begin : g_plain
         assign shown = rd_word;
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         rdata <= '0;
      end else if (rd_en) begin
         rdata <= in_range ? shown : '0;
      end
   end

   // R5: an out-of-range read returns zero
   p_oob_zero_r5: assert property (@(posedge clk) disable iff (!rst_n)
      $past(rd_en && !in_range) |-> (rdata == '0));

endmodule

// File: rtl/sysctl_regfile.sv
module sysctl_regfile
   import sysctl_pkg::*;
#(
   parameter int unsigned ADDR_W     = 12,
   parameter int unsigned DATA_W     = 32,
   parameter int unsigned WORDS      = 512,
   parameter int unsigned CMD_OFFSET = 'hF00,
   parameter bit          FORCE_EN   = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              bus_sel,
   input  logic              bus_write,
   input  logic [ADDR_W-1:0] bus_addr,
   input  logic [DATA_W-1:0] bus_wdata,
   output logic [DATA_W-1:0] bus_rdata,
   output logic              bad_access,
   output logic              reset_req,
   output logic              shutdown_req
);

   localparam int unsigned IDX_W = $clog2(WORDS);
   localparam logic [ADDR_W:0] LIMIT = (ADDR_W + 1)'(WORDS * 4);
   localparam logic [ADDR_W-1:0] CMD_A = ADDR_W'(CMD_OFFSET);

   generate
      if (DATA_W != 32) begin : g_bad_width
         $error("sysctl_regfile: DATA_W must be 32");
      end
      if (WORDS * 4 > (1 << ADDR_W)) begin : g_bad_depth
         $error("sysctl_regfile: storage exceeds the address window");
      end
      if (CMD_OFFSET >= (1 << ADDR_W)) begin : g_bad_cmd
         $error("sysctl_regfile: command offset outside the window");
      end
   endgenerate

   logic             in_range;
   logic             wr_ok;
   logic             rd_en;
   logic             cmd_hit;
   logic [IDX_W-1:0] idx;
   logic [DATA_W-1:0] word;

   assign in_range = ({1'b0, bus_addr} < LIMIT);
   assign idx      = bus_addr[IDX_W+1:2];
   assign wr_ok    = bus_sel && bus_write && in_range;
   assign rd_en    = bus_sel && !bus_write;
   assign cmd_hit  = bus_sel && bus_write && (bus_addr == CMD_A);

   sysctl_store #(.WORDS(WORDS), .DATA_W(DATA_W)) u_store (
      .clk     (clk),
      .rst_n   (rst_n),
      .wr_en   (wr_ok),
      .wr_idx  (idx),
      .wr_data (bus_wdata),
      .rd_idx  (idx),
      .rd_word (word)
   );

   sysctl_read_path #(.WORDS(WORDS), .DATA_W(DATA_W), .FORCE_EN(FORCE_EN)) u_read (
      .clk      (clk),
      .rst_n    (rst_n),
      .rd_en    (rd_en),
      .in_range (in_range),
      .rd_idx   (idx),
      .rd_word  (word),
      .rdata    (bus_rdata)
   );

   sysctl_cmd_decode #(.DATA_W(DATA_W)) u_cmd (
      .clk          (clk),
      .rst_n        (rst_n),
      .cmd_hit      (cmd_hit),
      .cmd_data     (bus_wdata),
      .reset_req    (reset_req),
      .shutdown_req (shutdown_req)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         bad_access <= 1'b0;
      end else begin
         bad_access <= bus_sel && !in_range;
      end
   end

   // R8: the flag only follows an access to the unbacked half
   p_bad_source_r8: assert property (@(posedge clk) disable iff (!rst_n)
      bad_access |-> $past(bus_sel && (bus_addr >= LIMIT[ADDR_W-1:0] || LIMIT[ADDR_W])));

   // R6: a reset request traces back to a command write of 1 or 2
   p_reset_src_r6: assert property (@(posedge clk) disable iff (!rst_n)
      reset_req |-> $past(bus_sel && bus_write && bus_addr == CMD_A &&
                          (bus_wdata == DATA_W'(1) || bus_wdata == DATA_W'(2))));

   // R7: a shutdown request traces back to a command write of 3
   p_off_src_r7: assert property (@(posedge clk) disable iff (!rst_n)
      shutdown_req |-> $past(bus_sel && bus_write && bus_addr == CMD_A &&
                             bus_wdata == DATA_W'(3)));

   // R3: forced status bits show on reads of the flagged words
   p_force_bits_r3: assert property (@(posedge clk) disable iff (!rst_n)
      $past(bus_sel && !bus_write && bus_addr == ADDR_W'('h108)) |->
         (bus_rdata[29:28] == 2'b11));

endmodule

// File: tb/sysctl_regfile_test.sv
`timescale 1ns/1ps
module sysctl_regfile_test;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        bus_sel = 1'b0;
   logic        bus_write = 1'b0;
   logic [11:0] bus_addr = '0;
   logic [31:0] bus_wdata = '0;
   logic [31:0] bus_rdata;
   logic        bad_access;
   logic        reset_req;
   logic        shutdown_req;

   int checks = 0;
   int errors = 0;
   logic [31:0] model [512];

   always #2.5 clk = ~clk;

   sysctl_regfile uut (
      .clk          (clk),
      .rst_n        (rst_n),
      .bus_sel      (bus_sel),
      .bus_write    (bus_write),
      .bus_addr     (bus_addr),
      .bus_wdata    (bus_wdata),
      .bus_rdata    (bus_rdata),
      .bad_access   (bad_access),
      .reset_req    (reset_req),
      .shutdown_req (shutdown_req)
   );

   function automatic logic [31:0] exp_boot(input int idx);
      case (idx)
         'h40:    return 32'h05F2_0121;
         'h41:    return 32'h0000_0002;
         'h42:    return 32'h05F3_0121;
         'h43:    return 32'h05F4_0121;
         default: return 32'h0;
      endcase
   endfunction

   function automatic logic [31:0] exp_read(input logic [11:0] a);
      logic [31:0] v;
      if (a >= 12'h800) return 32'h0;
      v = model[a[10:2]];
      if (a == 12'h100 || a == 12'h108 || a == 12'h10C) v = v | 32'h3000_0000;
      return v;
   endfunction

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s: actual 0x%08h expected 0x%08h", req, act, exp);
      end
   endtask

   // one access; all results sampled at the falling edge after the capturing edge
   task automatic access(input logic wr, input logic [11:0] a, input logic [31:0] d);
      logic oob;
      logic rq;
      logic off;
      oob = (a >= 12'h800);
      rq  = wr && a == 12'hF00 && (d == 32'd1 || d == 32'd2);
      off = wr && a == 12'hF00 && d == 32'd3;
      @(negedge clk);
      bus_sel = 1'b1; bus_write = wr; bus_addr = a; bus_wdata = d;
      @(negedge clk);
      bus_sel = 1'b0; bus_write = 1'b0;
      if (!wr) chk(oob ? "R5" : "R2", bus_rdata, exp_read(a));
      chk("R8", 32'(bad_access), 32'(oob));
      chk("R6", 32'(reset_req), 32'(rq));
      chk("R7", 32'(off ? 1 : 0), 32'(shutdown_req));
      if (wr && !oob) model[a[10:2]] = d;
   endtask

   task automatic pulses_clear();
      @(negedge clk);
      chk("R9 reset pulse one cycle", 32'(reset_req), 32'd0);
      chk("R9 shutdown pulse one cycle", 32'(shutdown_req), 32'd0);
      chk("R8 flag one cycle", 32'(bad_access), 32'd0);
   endtask

   initial begin
      repeat (40000) @(posedge clk);
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

   initial begin
      void'($urandom(32'd20240611));
      for (int i = 0; i < 512; i++) model[i] = exp_boot(i);
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      chk("R8 reset idle", 32'(bad_access), 32'd0);
      chk("R6 reset idle", 32'(reset_req), 32'd0);

      // R1: boot values, raw word at 0x104 and forced view of the others
      access(1'b0, 12'h104, 32'h0);
      access(1'b0, 12'h100, 32'h0);
      access(1'b0, 12'h108, 32'h0);
      access(1'b0, 12'h10C, 32'h0);
      chk("R1 word 0x104", model['h41], 32'h2);
      access(1'b0, 12'h000, 32'h0);
      access(1'b0, 12'h7FC, 32'h0);
      access(1'b0, 12'h110, 32'h0);

      // R2: edge words of the backed range
      access(1'b1, 12'h000, 32'hDEAD_BEEF);
      access(1'b1, 12'h7FC, 32'h1234_5678);
      access(1'b0, 12'h000, 32'h0);
      access(1'b0, 12'h7FC, 32'h0);

      // R3: stored bits 29:28 survive; unflagged 0x104 not forced
      access(1'b1, 12'h108, 32'h0000_00A5);
      access(1'b0, 12'h108, 32'h0);
      access(1'b1, 12'h104, 32'h0000_0011);
      access(1'b0, 12'h104, 32'h0);
      access(1'b1, 12'h100, 32'hC000_0000);
      access(1'b0, 12'h100, 32'h0);

      // R4: no aliasing from 0x800 onto word 0
      access(1'b1, 12'h800, 32'hFFFF_FFFF);
      pulses_clear();
      access(1'b0, 12'h000, 32'h0);
      access(1'b1, 12'hFFC, 32'h5555_5555);
      access(1'b0, 12'h7FC, 32'h0);
      access(1'b0, 12'hA00, 32'h0);

      // R6/R7: every command code
      for (int c = 0; c < 6; c++) begin
         access(1'b1, 12'hF00, 32'(c));
         pulses_clear();
      end
      access(1'b1, 12'hF00, 32'h8000_0003);
      access(1'b1, 12'hF04, 32'd3);
      access(1'b0, 12'hF00, 32'd0);

      // back-to-back commands: shutdown then reset
      access(1'b1, 12'hF00, 32'd3);
      access(1'b1, 12'hF00, 32'd1);
      pulses_clear();

      // mixed random traffic
      for (int n = 0; n < 600; n++) begin
         int          r;
         logic [11:0] a;
         logic [31:0] d;
         logic        w;
         r = int'($urandom % 10);
         if (r < 6)      a = 12'($urandom % 512) << 2;
         else if (r < 8) a = 12'h800 + (12'($urandom % 512) << 2);
         else            a = 12'hF00;
         d = (a == 12'hF00) ? 32'($urandom % 5) : $urandom;
         w = 1'($urandom % 2);
         access(w, a, d);
      end

      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

endmodule